// File: doc/BRIEF.md
# Multiplexed External Data Bus Controller

This block carries out data-memory transfers for a processor core over an external bus in the style of the classic 8-bit microcontroller bus. It takes a single read or write request with a 24-bit address, split into page, high and low bytes, and runs one complete bus cycle on two 8-bit ports. The low port first carries the low address byte and then carries the data. The high port first carries the page byte and then the high address byte. One address strobe (ALE) and two active-low strobes, one for reads and one for writes, control the external latches and the memory.

The board latches both ports on the falling edge of ALE. This gives a 16-Mbyte data space. The page byte is driven on the high port only while ALE is active, so a board with no latch on that port sees a plain 64-kbyte space with no mode setting. The strobe width comes from a configuration input that is captured when a request is accepted. A request is accepted only while the controller is idle. Any request made while a cycle is in flight waits until the controller returns to idle. Every cycle, read or write, ends with a one-clock done pulse. On a read, the byte taken from the bus is returned with that pulse.

Each port is brought out as a separate output, output enable and input. The pad ring builds the bidirectional pin from these signals.

Top module: `xbus_ctrl`

## Requirements
- R1: While rst_n is low, and in idle, the outputs are: ale=0, rd_n=1, wr_n=1, lo_oe=0, hi_oe=0 and rsp_done=0. In idle req_ready=1.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the acceptance edge until the controller is back in idle. A request held during that time is not lost. It is accepted on the first edge after idle returns.
- R3: The clock after acceptance is the address phase. In this phase ale=1, lo_out=req_addr[7:0] and hi_out=req_addr[23:16], with lo_oe=1 and hi_oe=1 and both strobes high.
- R4: The address-hold phase lasts one clock after ALE falls. In this phase ale=0, both ports keep the address bytes of R3 with both output enables at 1, and both strobes stay high.
- R5: In the data phase hi_out=req_addr[15:8]. The strobe (rd_n for a read, wr_n for a write) is low for exactly cfg_hold+1 clocks. cfg_hold is captured at acceptance, and later changes to it have no effect on a cycle already accepted. The two strobes are never low together.
- R6: On a write (req_write=1), lo_oe=1 and lo_out=req_wdata through the data phase and the end phase.
- R7: On a read (req_write=0), lo_oe=0 through the data phase and the end phase. rsp_rdata takes lo_in as it was on the last clock of the data phase. rsp_rdata holds that value through later writes until the next read.
- R8: After the data phase comes one end clock. In this clock both strobes are high, hi_out and lo_out keep their data-phase values, and rsp_done=1. The controller then goes to idle, so rsp_done lasts exactly one clock.
- R9: A memory that ignores the page byte sees the same low and high address for any page value. Cycles that differ only in page therefore reach the same location on a 64-kbyte board. On a 16-Mbyte board they reach different locations.
- R10: Driving rst_n low at any point, including in the middle of a strobe, gives the R1 output values at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Address as page : high : low bytes |
| req_wdata | input | 8 | Write data |
| cfg_hold | input | WAIT_W (3) | Strobe length minus one, captured at acceptance |
| rsp_done | output | 1 | One-clock pulse at the end of each cycle |
| rsp_rdata | output | 8 | Last byte read |
| lo_out | output | 8 | Low port output value (address low byte, then data) |
| lo_oe | output | 1 | Low port output enable |
| lo_in | input | 8 | Low port input value from the pad |
| hi_out | output | 8 | High port output value (page byte, then high address byte) |
| hi_oe | output | 1 | High port output enable |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe to memory output enable, active low |
| wr_n | output | 1 | Write strobe to memory write enable, active low |

## Verification
The assertions assume that the request fields stay stable while req_valid is high and req_ready is low. They also assume that rst_n is released away from the clock edge. The bench keeps to both assumptions. It drives every input only on falling clock edges. While it waits out a stall, it never changes the fields of a pending request. It changes cfg_hold only after acceptance, to show that the captured value is the one used. The memory model on the bench side latches and stores mid-cycle, so it never races the strobes.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3 * BYTE_W;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_AHLD = 3'd2,
    PH_DATA = 3'd3,
    PH_END  = 3'd4
  } phase_t;

  typedef struct packed {
    logic              wr;
    logic [BYTE_W-1:0] pg;
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] wd;
  } xreq_t;

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [WAIT_W-1:0] hold_q,
  output phase_t            ph,
  output logic              req_ready,
  output logic              accept,
  output logic              last_data
);

  localparam logic [WAIT_W-1:0] CNT_ZERO = '0;
  localparam logic [WAIT_W-1:0] CNT_ONE  = {{(WAIT_W-1){1'b0}}, 1'b1};

  phase_t            ph_nx;
  logic [WAIT_W-1:0] cnt, cnt_nx;

  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign last_data = (ph == PH_DATA) && (cnt == CNT_ZERO);

  // next-state process
  always_comb begin
    ph_nx  = ph;
    cnt_nx = cnt;
    case (ph)
      PH_IDLE: if (req_valid) ph_nx = PH_ADDR;
      PH_ADDR: ph_nx = PH_AHLD;
      PH_AHLD: begin
        ph_nx  = PH_DATA;
        cnt_nx = hold_q;
      end
      PH_DATA: begin
        if (cnt == CNT_ZERO) ph_nx = PH_END;
        else                 cnt_nx = cnt - CNT_ONE;
      end
      PH_END:  ph_nx = PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= CNT_ZERO;
    end else begin
      ph  <= ph_nx;
      cnt <= cnt_nx;
    end
  end

  // R2: an accepted request always starts with the address phase
  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ph == PH_ADDR));

  // R2: nothing is accepted while a cycle is in flight
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE) |-> !accept);

  // R5: the data phase is entered only from the address-hold phase
  p_data_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_DATA) && ($past(ph) != PH_DATA)) |-> ($past(ph) == PH_AHLD));

endmodule

// File: rtl/xbus_hold.sv
module xbus_hold
  import xbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              last_data,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic [WAIT_W-1:0] cfg_hold,
  input  logic [BYTE_W-1:0] lo_in,
  output xreq_t             q,
  output logic [WAIT_W-1:0] hold_q,
  output logic [BYTE_W-1:0] rdata_q
);

  xreq_t             q_nx;
  logic [WAIT_W-1:0] hold_nx;
  logic [BYTE_W-1:0] rdata_nx;
  logic              rd_cap_en;

  assign rd_cap_en = last_data && !q.wr;

  // next-state process with explicit clock enables
  always_comb begin
    q_nx     = q;
    hold_nx  = hold_q;
    rdata_nx = rdata_q;
    if (accept) begin
      q_nx.wr = req_write;
      q_nx.pg = req_addr[3*BYTE_W-1:2*BYTE_W];
      q_nx.hi = req_addr[2*BYTE_W-1:BYTE_W];
      q_nx.lo = req_addr[BYTE_W-1:0];
      q_nx.wd = req_wdata;
      hold_nx = cfg_hold;
    end
    if (rd_cap_en) rdata_nx = lo_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      hold_q  <= '0;
      rdata_q <= '0;
    end else begin
      q       <= q_nx;
      hold_q  <= hold_nx;
      rdata_q <= rdata_nx;
    end
  end

  // R7: read data changes only on the last data clock of a read
  p_rdata_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_cap_en) |-> $stable(rdata_q));

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            ph,
  input  xreq_t             q,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [BYTE_W-1:0] lo_out,
  output logic              lo_oe,
  output logic [BYTE_W-1:0] hi_out,
  output logic              hi_oe,
  output logic              done
);

  logic addr_ph, xfer_ph;

  assign addr_ph = (ph == PH_ADDR) || (ph == PH_AHLD);
  assign xfer_ph = (ph == PH_DATA) || (ph == PH_END);

  always_comb begin
    ale    = (ph == PH_ADDR);
    rd_n   = !((ph == PH_DATA) && !q.wr);
    wr_n   = !((ph == PH_DATA) &&  q.wr);
    done   = (ph == PH_END);
    hi_oe  = addr_ph || xfer_ph;
    lo_oe  = addr_ph || (xfer_ph && q.wr);
    hi_out = '0;
    lo_out = '0;
    if (addr_ph) begin
      hi_out = q.pg;
      lo_out = q.lo;
    end else if (xfer_ph) begin
      hi_out = q.hi;
      if (q.wr) lo_out = q.wd;
    end
  end

  // R4: both address bytes are held, and driven, for the clock after ALE falls
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ($stable(lo_out) && $stable(hi_out) && lo_oe && hi_oe));

  // R5: the two strobes are never low together
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R7: the low port is released whenever the read strobe is low
  p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !lo_oe);

  // R8: done follows a strobe clock, with both strobes high again
  p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!rd_n || !wr_n) && rd_n && wr_n));

  // R8: done lasts one clock
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: ALE is a single-clock pulse
  p_ale_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [23:0]       req_addr,
  input  logic [7:0]        req_wdata,
  input  logic [WAIT_W-1:0] cfg_hold,
  output logic              rsp_done,
  output logic [7:0]        rsp_rdata,
  output logic [7:0]        lo_out,
  output logic              lo_oe,
  input  logic [7:0]        lo_in,
  output logic [7:0]        hi_out,
  output logic              hi_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);

  phase_t            ph;
  xreq_t             q;
  logic [WAIT_W-1:0] hold_q;
  logic              accept;
  logic              last_data;

  xbus_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .hold_q    (hold_q),
    .ph        (ph),
    .req_ready (req_ready),
    .accept    (accept),
    .last_data (last_data)
  );

  xbus_hold #(.WAIT_W(WAIT_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .last_data (last_data),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cfg_hold  (cfg_hold),
    .lo_in     (lo_in),
    .q         (q),
    .hold_q    (hold_q),
    .rdata_q   (rsp_rdata)
  );

  xbus_pins u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph     (ph),
    .q      (q),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .lo_out (lo_out),
    .lo_oe  (lo_oe),
    .hi_out (hi_out),
    .hi_oe  (hi_oe),
    .done   (rsp_done)
  );

  // R1: in idle nothing is driven and no strobe is active
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ale && rd_n && wr_n && !lo_oe && !hi_oe && !rsp_done));

endmodule

// File: tb/sim_xbus_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_ctrl;

  localparam int WAIT_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write;
  logic [23:0]       req_addr;
  logic [7:0]        req_wdata;
  logic [WAIT_W-1:0] cfg_hold;
  logic              req_ready, rsp_done, lo_oe, hi_oe, ale, rd_n, wr_n;
  logic [7:0]        rsp_rdata, lo_out, hi_out;
  logic [7:0]        lo_in;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xbus_ctrl #(.WAIT_W(WAIT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_hold(cfg_hold), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out),
    .hi_oe(hi_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  // ---------------- external latches and memory model ----------------
  logic [7:0] lat_lo, lat_pg;
  bit         pg_used;
  logic [7:0] mem [logic [23:0]];

  function automatic logic [23:0] mkey();
    return {pg_used ? lat_pg : 8'h00, hi_out, lat_lo};
  endfunction

  always @(negedge clk) begin
    if (ale) begin
      lat_lo = lo_out;
      lat_pg = hi_out;
    end
    if (!wr_n) mem[mkey()] = lo_out;
    if (!rd_n) lo_in = mem.exists(mkey()) ? mem[mkey()] : 8'h00;
    else       lo_in = 8'hEE;
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ {a[15:8] + 8'h5A} ^ (a[23:16] << 1);
  endfunction

  // Idle / reset pin values
  task automatic chk_quiet(input string req);
    chk(ale == 1'b0, req, ale, 0);
    chk(rd_n == 1'b1 && wr_n == 1'b1, req, {rd_n, wr_n}, 2'b11);
    chk(lo_oe == 1'b0 && hi_oe == 1'b0, req, {lo_oe, hi_oe}, 2'b00);
    chk(rsp_done == 1'b0, req, rsp_done, 0);
  endtask

  // One full transfer, checked clock by clock at falling edges.
  task automatic xfer(input bit wr, input logic [23:0] a, input logic [7:0] d,
                      input int len, input bit early, input bit do_rd_chk,
                      input logic [7:0] exp_rd, input logic [7:0] hold_rd);
    int stalls = 0;
    if (!early) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    cfg_hold  = WAIT_W'(len);
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      chk(req_valid && req_addr == a, "R2 request held while stalled", req_addr, a);
    end
    chk(stalls == (early ? 1 : 0), "R2 stall count", stalls, early ? 1 : 0);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_hold  = ~WAIT_W'(len);  // R5: later changes must not matter
    req_addr  = ~a;
    req_wdata = ~d;
    // address phase
    chk(ale == 1'b1 && req_ready == 1'b0, "R3 ale high, not ready", {ale, req_ready}, 2'b10);
    chk(lo_out == a[7:0] && hi_out == a[23:16], "R3 address bytes",
        {hi_out, lo_out}, {a[23:16], a[7:0]});
    chk(lo_oe && hi_oe && rd_n && wr_n, "R3 enables and strobes",
        {lo_oe, hi_oe, rd_n, wr_n}, 4'hF);
    @(negedge clk);
    // address-hold phase
    chk(ale == 1'b0 && rd_n && wr_n, "R4 ale low strobes high", {ale, rd_n, wr_n}, 3'b011);
    chk(lo_out == a[7:0] && hi_out == a[23:16] && lo_oe && hi_oe, "R4 address held",
        {hi_out, lo_out}, {a[23:16], a[7:0]});
    // data phase
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      chk(hi_out == a[15:8], "R5 high address byte", hi_out, a[15:8]);
      chk(wr ? (!wr_n && rd_n) : (!rd_n && wr_n), "R5 strobe low",
          {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
      if (wr) chk(lo_oe && lo_out == d, "R6 write data driven", {lo_oe, lo_out}, {1'b1, d});
      else    chk(!lo_oe, "R7 low port released", lo_oe, 0);
      chk(!rsp_done, "R8 no done in data phase", rsp_done, 0);
    end
    @(negedge clk);
    // end phase
    chk(rsp_done && rd_n && wr_n, "R8 end clock", {rsp_done, rd_n, wr_n}, 3'b111);
    chk(hi_out == a[15:8], "R8 high byte held", hi_out, a[15:8]);
    if (wr) begin
      chk(lo_oe && lo_out == d, "R6 write data held at end", {lo_oe, lo_out}, {1'b1, d});
      chk(rsp_rdata == hold_rd, "R7 read data kept across write", rsp_rdata, hold_rd);
    end else begin
      chk(!lo_oe, "R7 released at end", lo_oe, 0);
      if (do_rd_chk) chk(rsp_rdata == exp_rd, "R7 read data", rsp_rdata, exp_rd);
    end
  endtask

  logic [7:0] last_rd;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; cfg_hold = '0; pg_used = 1'b1; lo_in = 8'hEE;
    lat_lo = '0; lat_pg = '0;
    #12;
    chk_quiet("R1 during reset");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_quiet("R1 idle after reset");
    chk(req_ready == 1'b1, "R1 ready in idle", req_ready, 1);
    chk(rsp_rdata == 8'h00, "R1 read data reset", rsp_rdata, 0);
    last_rd = 8'h00;

    // Sweep strobe lengths and addresses: write, then read back.
    for (int len = 0; len < (1 << WAIT_W); len++) begin
      for (int k = 0; k < 4; k++) begin
        logic [23:0] a;
        a = {8'(k * 37 + len), 8'(k * 91 + 3), 8'(len * 29 + k)};
        xfer(1'b1, a, pat(a), len, 1'b0, 1'b0, 8'h00, last_rd);
        xfer(1'b0, a, 8'h00, len, 1'b0, 1'b1, pat(a), 8'h00);
        last_rd = pat(a);
      end
    end

    // Back-to-back: next request raised during the end clock stalls one clock.
    xfer(1'b1, 24'h10_00_00, 8'h42, 1, 1'b0, 1'b0, 8'h00, last_rd);
    xfer(1'b0, 24'h10_00_00, 8'h00, 0, 1'b1, 1'b1, 8'h42, 8'h00);
    last_rd = 8'h42;
    xfer(1'b1, 24'hFF_FF_FF, 8'hA5, 2, 1'b1, 1'b0, 8'h00, last_rd);
    xfer(1'b0, 24'hFF_FF_FF, 8'h00, 2, 1'b1, 1'b1, 8'hA5, 8'h00);
    last_rd = 8'hA5;

    // R9: distinct pages on a 16-Mbyte board, aliasing on a 64-kbyte board.
    xfer(1'b1, 24'h01_3C_C3, 8'h11, 0, 1'b0, 1'b0, 8'h00, last_rd);
    xfer(1'b1, 24'h02_3C_C3, 8'h22, 0, 1'b0, 1'b0, 8'h00, last_rd);
    xfer(1'b0, 24'h01_3C_C3, 8'h00, 0, 1'b0, 1'b1, 8'h11, 8'h00);
    chk(rsp_rdata == 8'h11, "R9 page 1 distinct", rsp_rdata, 8'h11);
    xfer(1'b0, 24'h02_3C_C3, 8'h00, 0, 1'b0, 1'b1, 8'h22, 8'h00);
    chk(rsp_rdata == 8'h22, "R9 page 2 distinct", rsp_rdata, 8'h22);
    pg_used = 1'b0;
    xfer(1'b1, 24'h05_77_88, 8'h9C, 1, 1'b0, 1'b0, 8'h00, 8'h22);
    xfer(1'b0, 24'hE0_77_88, 8'h00, 1, 1'b0, 1'b1, 8'h9C, 8'h00);
    chk(rsp_rdata == 8'h9C, "R9 page ignored on 64-kbyte board", rsp_rdata, 8'h9C);
    pg_used = 1'b1;

    // R10: reset in the middle of a write strobe.
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 24'h12_34_56;
    req_wdata = 8'h77; cfg_hold = 3'd5;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(!wr_n, "R10 strobe active before reset", wr_n, 0);
    #2 rst_n = 1'b0;
    #1 chk_quiet("R10 async reset mid-strobe");
    chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_quiet("R10 idle after release");
    xfer(1'b0, 24'h10_00_00, 8'h00, 0, 1'b0, 1'b1, 8'h42, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at %0t: actual running expected finished", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule